// File: doc/BRIEF.md
# Script Register Operation ALU

This block carries out the register-operation class of a script processor's instructions. It takes the first 32-bit word of each instruction and decodes a data-path selector, an operator, an 8-bit immediate and an 8-bit register address. It then computes an 8-bit result together with a carry flag. Depending on the data path, the result goes to one of two places. It may be written into the register file, taking the block's own byte register (called SFBR here) as the first operand. It may be loaded into SFBR, taking a register-file byte as the first operand. Or it may be written back in place to the register-file byte it was read from.

The register file sits outside the block. The block presents a read address and expects the read data back in the same cycle. It issues at most one write per instruction. The carry flag is kept between instructions, so shifts and add-with-carry can chain across several instructions to build multi-byte arithmetic. One instruction can be accepted on every cycle. Each result takes effect one cycle after the instruction is accepted, and a done pulse follows one cycle after that.

Top module: `scr_regop_alu`

## Requirements
- R1: The data-path selector is instruction bits 29:27, the operator is bits 26:24 and the immediate is bits 15:8. Operator codes are: 0 move (the result is the second operand), 1 shift left, 2 OR, 3 XOR, 4 AND, 5 shift right, 6 add, 7 add with carry.
- R2: The register address is bit 7 of the instruction as its MSB, followed by instruction bits 22:16. The same address is used to read and to write the register file.
- R3: Selector 5 writes op(SFBR, immediate) into the addressed register. SFBR is left unchanged.
- R4: Selector 6 loads op(register, immediate) into SFBR. No register-file write is issued.
- R5: Selector 7 writes op(register, second) back to the same register. The second operand is SFBR when instruction bit 23 is 1, otherwise the immediate. Bit 23 has no effect under selectors 5 and 6.
- R6: Move, OR, XOR and AND leave the carry flag unchanged.
- R7: Shift left puts the old carry into result bit 0 and moves operand bit 7 into the carry.
- R8: Shift right puts the old carry into result bit 7 and moves operand bit 0 into the carry.
- R9: Add sets the carry to 1 exactly when the unsigned 8-bit sum overflows.
- R10: Add with carry adds the old carry as well. Its carry is the overflow of the full sum, including the case where the result equals the second operand with an incoming carry of 1.
- R11: Reset clears the carry, SFBR and done. The carry persists across instructions until an arithmetic or shift operation changes it.
- R12: A write, or an SFBR or carry update, takes effect on the clock edge that ends the cycle after the accepting edge. Done is high for the cycle after that. Instructions may be issued on consecutive cycles.
- R13: Selector values 0 to 4 issue no write and change neither SFBR nor the carry, but done still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction word valid this cycle |
| insn | input | 32 | First instruction word |
| rf_raddr | output | 8 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 8 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |
| sfbr_q | output | 8 | Current SFBR value |
| carry_q | output | 1 | Current carry flag |
| done | output | 1 | Instruction completion pulse |

## Verification
The register-file write enable, address and data appear in the cycle after start is sampled. The written byte, SFBR and the carry are settled one edge later, and done is high in that same cycle. The bench drives inputs on falling edges. It checks the write strobe on the first falling edge after issue and checks all results and done on the second. The expected values come from an integer model that chains the carry across the whole vector table. A back-to-back pair checks that the second instruction reads the byte and the carry left by the first.

// File: rtl/scr_alu_pkg.sv
package scr_alu_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned IW      = 32;
  localparam int unsigned AW      = 8;
  // field positions that the decoder depends on
  localparam int unsigned SEL_LO  = 27;
  localparam int unsigned OP_LO   = 24;
  localparam int unsigned SRC_BIT = 23;
  localparam int unsigned ADR_LO  = 16;
  localparam int unsigned IMM_LO  = 8;
  localparam int unsigned ADR_MSB = 7;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0, OP_SHL = 3'd1, OP_OR  = 3'd2, OP_XOR = 3'd3,
    OP_AND = 3'd4, OP_SHR = 3'd5, OP_ADD = 3'd6, OP_ADC = 3'd7
  } alu_op_e;

  localparam logic [2:0] PATH_TO_REG  = 3'd5;
  localparam logic [2:0] PATH_TO_SFBR = 3'd6;
  localparam logic [2:0] PATH_RMW     = 3'd7;

  typedef struct packed {
    logic          legal;
    logic [2:0]    path;
    alu_op_e       op;
    logic          use_sfbr;
    logic [AW-1:0] addr;
    logic [DW-1:0] imm;
  } regop_t;

  // returns {carry_out, result}
  function automatic logic [DW:0] alu_calc(alu_op_e op, logic [DW-1:0] a,
                                           logic [DW-1:0] b, logic cin);
    logic [DW:0] r;
    case (op)
      OP_MOV: r = {cin, b};
      OP_SHL: r = {a, cin};
      OP_OR:  r = {cin, a | b};
      OP_XOR: r = {cin, a ^ b};
      OP_AND: r = {cin, a & b};
      OP_SHR: r = {a[0], cin, a[DW-1:1]};
      OP_ADD: r = {1'b0, a} + {1'b0, b};
      default: r = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    endcase
    return r;
  endfunction

  function automatic logic op_sets_carry(alu_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_ADD) || (op == OP_ADC);
  endfunction
endpackage

// File: rtl/scr_regop_decode.sv
module scr_regop_decode
  import scr_alu_pkg::*;
(
  input  logic [IW-1:0] insn,
  output regop_t        dec
);
  logic [2:0] sel;
  assign sel = insn[SEL_LO +: 3];

  always_comb begin
    dec.path     = sel;
    dec.legal    = (sel == PATH_TO_REG) || (sel == PATH_TO_SFBR) || (sel == PATH_RMW);
    dec.op       = alu_op_e'(insn[OP_LO +: 3]);
    dec.use_sfbr = insn[SRC_BIT] && (sel == PATH_RMW);
    dec.addr     = {insn[ADR_MSB], insn[ADR_LO +: AW-1]};
    dec.imm      = insn[IMM_LO +: DW];
  end
endmodule

// File: rtl/scr_regop_exec.sv
module scr_regop_exec
  import scr_alu_pkg::*;
(
  input  regop_t        dec,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] sfbr,
  input  logic          carry,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] result,
  output logic          carry_nxt,
  output logic          carry_upd,
  output logic          to_reg,
  output logic          to_sfbr
);
  logic [DW-1:0] op_b;
  logic [DW:0]   calc;

  always_comb begin
    op_a = '0;
    op_b = dec.imm;
    case (dec.path)
      PATH_TO_REG:  op_a = sfbr;
      PATH_TO_SFBR: op_a = rd_data;
      PATH_RMW: begin
        op_a = rd_data;
        op_b = dec.use_sfbr ? sfbr : dec.imm;
      end
      default: op_a = '0;
    endcase
  end

  assign calc      = alu_calc(dec.op, op_a, op_b, carry);
  assign result    = calc[DW-1:0];
  assign carry_nxt = calc[DW];
  assign carry_upd = dec.legal && op_sets_carry(dec.op);
  assign to_reg    = dec.legal && (dec.path != PATH_TO_SFBR);
  assign to_sfbr   = dec.legal && (dec.path == PATH_TO_SFBR);
endmodule

// File: rtl/scr_regop_state.sv
module scr_regop_state
  import scr_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_vld,
  input  logic          to_sfbr,
  input  logic          carry_upd,
  input  logic          carry_nxt,
  input  logic [DW-1:0] result,
  output logic [DW-1:0] sfbr_q,
  output logic          carry_q,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sfbr_q  <= '0;
      carry_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= ex_vld;
      if (ex_vld && to_sfbr)   sfbr_q  <= result;
      if (ex_vld && carry_upd) carry_q <= carry_nxt;
    end
  end

  AST_SFBR_ONLY_PATH6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_vld && to_sfbr) |=> $stable(sfbr_q)); // R3
  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_vld && carry_upd) |=> $stable(carry_q)); // R6
endmodule

// File: rtl/scr_regop_alu.sv
module scr_regop_alu
  import scr_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] insn,
  output logic [AW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [AW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic [DW-1:0] sfbr_q,
  output logic          carry_q,
  output logic          done
);
  logic          ex_vld;
  logic [IW-1:0] ex_insn;
  regop_t        dec;
  logic [DW-1:0] op_a, result;
  logic          carry_nxt, carry_upd, to_reg, to_sfbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_vld  <= 1'b0;
      ex_insn <= '0;
    end else begin
      ex_vld <= start;
      if (start) ex_insn <= insn;
    end
  end

  scr_regop_decode u_dec (.insn(ex_insn), .dec(dec));

  scr_regop_exec u_exec (
    .dec(dec), .rd_data(rf_rdata), .sfbr(sfbr_q), .carry(carry_q),
    .op_a(op_a), .result(result), .carry_nxt(carry_nxt),
    .carry_upd(carry_upd), .to_reg(to_reg), .to_sfbr(to_sfbr)
  );

  scr_regop_state u_state (
    .clk(clk), .rst_n(rst_n), .ex_vld(ex_vld), .to_sfbr(to_sfbr),
    .carry_upd(carry_upd), .carry_nxt(carry_nxt), .result(result),
    .sfbr_q(sfbr_q), .carry_q(carry_q), .done(done)
  );

  assign rf_raddr = dec.addr;
  assign rf_waddr = dec.addr;
  assign rf_wdata = result;
  assign rf_we    = ex_vld && to_reg;

  AST_DONE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 done); // R12
  AST_WE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> done); // R12
  AST_NO_WE_SFBR: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && dec.path == PATH_TO_SFBR) |-> !rf_we); // R4
  AST_NO_WE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && !dec.legal) |-> !rf_we); // R13
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && dec.legal && dec.op == OP_SHL) |=> carry_q == $past(op_a[DW-1])); // R7
  AST_SHR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld && dec.legal && dec.op == OP_SHR) |=> carry_q == $past(op_a[0])); // R8
endmodule

// File: tb/scr_regop_alu_tb.sv
module scr_regop_alu_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] insn = '0;
  logic [7:0]  rf_raddr, rf_rdata, rf_waddr, rf_wdata, sfbr_q;
  logic        rf_we, carry_q, done;
  logic [7:0]  rf [256];
  int          exp_mem [256];
  int          exp_sfbr, exp_carry;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  scr_regop_alu u_dut (.clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .sfbr_q(sfbr_q), .carry_q(carry_q), .done(done));

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  // {sel[2:0], op[2:0], bit23, addr[7:0], imm[7:0]}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {3'd6, 3'd0, 1'b0, 8'h00, 8'h5A},  // R4 R1 load SFBR
    {3'd5, 3'd2, 1'b0, 8'h85, 8'h0F},  // R3 R2 high address bit
    {3'd7, 3'd6, 1'b0, 8'h10, 8'hFF},  // R9 overflow
    {3'd7, 3'd7, 1'b0, 8'h11, 8'h00},  // R10 carry in
    {3'd7, 3'd1, 1'b0, 8'h90, 8'h00},  // R7
    {3'd7, 3'd5, 1'b0, 8'h91, 8'h00},  // R8
    {3'd7, 3'd3, 1'b1, 8'h20, 8'h77},  // R5 SFBR as operand
    {3'd6, 3'd4, 1'b1, 8'h20, 8'hF0},  // R5 bit23 ignored
    {3'd5, 3'd6, 1'b1, 8'h30, 8'hC0},  // R3 R9
    {3'd7, 3'd0, 1'b0, 8'h31, 8'h3C},  // R6 move
    {3'd7, 3'd2, 1'b0, 8'h32, 8'h81},  // R6 or
    {3'd2, 3'd6, 1'b0, 8'h33, 8'h99},  // R13 illegal
    {3'd7, 3'd7, 1'b0, 8'h34, 8'h10},  // R10
    {3'd7, 3'd4, 1'b0, 8'hFE, 8'h0F}   // R6 and
  };

  function automatic logic [31:0] mk(logic [22:0] v);
    logic [7:0] a;
    a = v[15:8];
    return {2'b01, v[22:20], v[19:17], v[16], a[6:0], v[7:0], a[7], 7'd0};
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic model(logic [31:0] w);
    int sel, op, a, b, r, c, adr;
    sel = w[29:27]; op = w[26:24]; b = w[15:8];
    adr = {w[7], w[22:16]};
    if (sel < 5) return;
    a = (sel == 5) ? exp_sfbr : exp_mem[adr];
    if (sel == 7 && w[23]) b = exp_sfbr;
    c = exp_carry;
    case (op)
      0: r = b;
      1: begin r = (a * 2 + exp_carry) % 256; c = (a >= 128); end
      2: r = a | b;
      3: r = a ^ b;
      4: r = a & b;
      5: begin r = a / 2 + exp_carry * 128; c = a % 2; end
      6: begin r = (a + b) % 256; c = (a + b) > 255; end
      default: begin r = (a + b + exp_carry) % 256; c = (a + b + exp_carry) > 255; end
    endcase
    exp_carry = c;
    if (sel == 6) exp_sfbr = r; else exp_mem[adr] = r;
  endtask

  function automatic string req_of(logic [31:0] w);
    case (w[26:24])
      3'd1: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      3'd7: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_all(logic [31:0] w);
    int adr;
    adr = {w[7], w[22:16]};
    if (w[29:27] < 5) begin
      check("R13 reg", rf[adr], exp_mem[adr]);
      check("R13 sfbr", sfbr_q, exp_sfbr);
      check("R13 carry", carry_q, exp_carry);
    end else begin
      check("R2/R3/R5 reg", rf[adr], exp_mem[adr]);
      check("R4 sfbr", sfbr_q, exp_sfbr);
      check({req_of(w), " carry"}, carry_q, exp_carry);
    end
  endtask

  task automatic run(logic [31:0] w);
    @(negedge clk); start = 1'b1; insn = w;
    @(negedge clk); start = 1'b0;
    check("R12 write strobe", rf_we, w[29:27] == 5 || w[29:27] == 7);
    check("R12 done early", done, 0);
    @(negedge clk);
    model(w);
    check("R12 done", done, 1);
    compare_all(w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] wa, wb;
    for (int i = 0; i < 256; i++) begin
      rf[i] = 8'((i * 7 + 3) % 256);
      exp_mem[i] = (i * 7 + 3) % 256;
    end
    exp_sfbr = 0; exp_carry = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset sfbr", sfbr_q, 0);
    check("R11 reset carry", carry_q, 0);
    check("R11 reset done", done, 0);
    check("R11 reset we", rf_we, 0);

    for (int k = 0; k < NV; k++) run(mk(VEC[k]));

    // R10 corner: operand 0xFF, carry in 1, result equals second operand
    run(mk({3'd7, 3'd0, 1'b0, 8'h40, 8'hFF}));
    run(mk({3'd7, 3'd6, 1'b0, 8'h41, 8'hFF}));  // forces carry 1
    run(mk({3'd7, 3'd7, 1'b0, 8'h40, 8'h42}));
    check("R10 equal case result", rf[8'h40], 8'h42);
    check("R10 equal case carry", carry_q, 1);

    // R12 back-to-back: second reads byte and carry left by first
    wa = mk({3'd7, 3'd6, 1'b0, 8'h50, 8'hF0});
    wb = mk({3'd7, 3'd1, 1'b0, 8'h50, 8'h00});
    @(negedge clk); start = 1'b1; insn = wa;
    @(negedge clk); insn = wb;
    check("R12 b2b first strobe", rf_we, 1);
    @(negedge clk); start = 1'b0;
    check("R12 b2b first done", done, 1);
    @(negedge clk);
    check("R12 b2b second done", done, 1);
    model(wa); model(wb);
    compare_all(wb);

    // R11 carry persists through logic ops, then reset clears it
    run(mk({3'd7, 3'd6, 1'b0, 8'h60, 8'hFF}));
    run(mk({3'd7, 3'd3, 1'b0, 8'h61, 8'h55}));
    check("R11 carry persists", carry_q, exp_carry);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_carry = 0; exp_sfbr = 0;
    check("R11 reset clears carry", carry_q, 0);
    check("R11 reset clears sfbr", sfbr_q, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule